// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block carries internal read, write and instruction-fetch requests out onto a multiplexed address/data bus that is either 8 or 16 bits wide. The internal side is a request/acknowledge port: the requester holds `req` with an address, byte enables and write data until a one-cycle `ack` returns. For reads, `ack` comes with the assembled read data. On the bus side the block produces an address strobe, a read strobe, two write-type strobes, an instruction-fetch flag and a half-rate bus clock. It samples a ready input, which stretches a cycle, and a width input, which can choose the bus width for each cycle.

All timing is counted in periods of `clk`, the oscillator clock. A bus cycle runs through an address period, a command period, a hold period and an end period. Wait states are always inserted in pairs of periods, so the bus clock keeps its phase. A configuration bit chooses between two strobe encodings. In the latch encoding there is an address-latch pulse, a plain write strobe and a high-byte enable. In the valid encoding there is an address-valid level, a low-byte write strobe and a high-byte write strobe. When a two-byte request meets an 8-bit cycle, the block runs two byte cycles back to back and then acknowledges.

Top module: `ebc_mux_bus`

## Requirements
- R1: A bus cycle with no wait state lasts 4 `clk` periods. In latch encoding (`cfg_adv`=0), `strobe` is high for exactly the first period of the cycle, and `clkout` is low in that period. `ack` rises 4+2N periods after the cycle's first period, where N is the number of wait states.
- R2: `ready` is sampled only at edges where `clkout` rises at the end of the hold period. Each low sample adds 2 periods. The command strobe (read or write) stays low for 2+2N periods.
- R3: Width selection by `cfg_bw`. 2'b11 means the width comes from `buswidth` (0 gives an 8-bit cycle, 1 gives a 16-bit cycle). 2'b01 fixes the width at 16 bits. 2'b00 and 2'b10 fix it at 8 bits. When the width is fixed, `buswidth` is ignored.
- R4: On an 8-bit cycle with `req_be`=2'b11, the block runs two cycles, the even byte first and then the odd byte, and gives a single `ack` after the second cycle. Any other request uses one cycle.
- R5: In valid encoding (`cfg_adv`=1), `strobe` is high when idle, goes low at the start of each cycle, stays low through the command, hold and wait periods, and is high in the end period.
- R6: In latch encoding, a write drives `wr_lo_n` low for every write. `wr_hi_n` goes low only when the cycle writes the high byte. `rd_n` stays high during writes, and the read and write strobes are never low together.
- R7: In valid encoding, `wr_lo_n` goes low only when the even byte is written, and `wr_hi_n` only when the odd byte is written.
- R8: `inst` is high for every period of a cycle that serves a fetch request (`req_fetch`=1), and low for reads and writes.
- R9: `clkout` toggles on every `clk` edge after reset.
- R10: While `rd_n` is low, `ad_oe` is 0. Read data is captured at the edge where `rd_n` rises. Byte lanes that are not enabled return 0.
- R11: After reset, no cycle is active: `ack`=0, `rd_n`=`wr_lo_n`=`wr_hi_n`=1, `ad_oe`=0 and `inst`=0. `ack` is a single-cycle pulse.
- R12: In the address period, `ad_oe`=1 and `ad_out` = {`req_addr`[15:1], odd}. odd is 1 for the second half of a split, and for a request with `req_be`=2'b10. On a 16-bit write, each enabled lane carries its byte of `req_wdata`. On an 8-bit write, `ad_out`[7:0] carries the addressed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_adv | input | 1 | 0: latch encoding, 1: valid encoding |
| cfg_bw | input | 2 | Width selection (see R3) |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | Write request |
| req_fetch | input | 1 | Instruction fetch (a read) |
| req_be | input | 2 | Byte enables, bit 0 is the even byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data, even byte in [7:0] |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| ad_out | output | 16 | Address/data out |
| ad_oe | output | 1 | Bus output enable |
| ad_in | input | 16 | Bus data in |
| strobe | output | 1 | Address latch pulse or address-valid level |
| rd_n | output | 1 | Read strobe |
| wr_lo_n | output | 1 | Write strobe or low-byte write strobe |
| wr_hi_n | output | 1 | High-byte enable or high-byte write strobe |
| inst | output | 1 | Fetch cycle flag |
| clkout | output | 1 | Half-rate bus clock |
| ready | input | 1 | Wait request when low |
| buswidth | input | 1 | Per-cycle width when dynamic |

## Verification
The address and the fetch flag are due in the same period in which the cycle's strobe first shows. The command strobes follow one period later and last 2+2N periods. Read data and `ack` appear 4+2N periods after the address period of the last cycle. The bench samples every output half a period after the edge, and takes the cycle start as the reference for each of these counts. Its memory model sets `ready` in the half period before each rising `clkout` edge, so the number of wait states per cycle is exact.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
    localparam int BUS_W  = 16;
    localparam int LANES  = BUS_W / 8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_CMD, PH_HOLD, PH_WAITA, PH_WAITB, PH_END
    } phase_e;

    typedef struct packed {
        phase_e            ph;
        logic              clk;
        logic              odd;
        logic              wide;
        logic              more;
        logic              ack;
        logic [BUS_W-1:0]  rdata;
    } seq_s;
endpackage

// File: rtl/ebc_strobe_enc.sv
module ebc_strobe_enc
    import ebc_pkg::*;
(
    input  phase_e           ph,
    input  logic             adv_mode,
    input  logic             we,
    input  logic [LANES-1:0] lanes,
    output logic             strobe,
    output logic             rd_n,
    output logic             lo_n,
    output logic             hi_n
);
    logic cmd;
    logic busy;

    always_comb begin
        cmd    = (ph == PH_CMD) || (ph == PH_HOLD) || (ph == PH_WAITA) || (ph == PH_WAITB);
        busy   = cmd || (ph == PH_ADDR);
        strobe = adv_mode ? ~busy : (ph == PH_ADDR);
        rd_n   = ~(cmd && !we);
        lo_n   = ~(cmd && we && (lanes[0] || !adv_mode));
        hi_n   = ~(cmd && we && lanes[1]);
    end
endmodule

// File: rtl/ebc_lane_map.sv
module ebc_lane_map
    import ebc_pkg::*;
(
    input  logic             wide,
    input  logic             odd,
    input  logic [LANES-1:0] be,
    input  logic [BUS_W-1:0] wdata,
    input  logic [BUS_W-1:0] bus_in,
    input  logic [BUS_W-1:0] rd_old,
    output logic [LANES-1:0] lanes,
    output logic [BUS_W-1:0] bus_wr,
    output logic [BUS_W-1:0] rd_new
);
    always_comb begin
        lanes  = wide ? be : (odd ? 2'b10 : 2'b01);
        bus_wr = wide ? wdata : {wdata[15:8], (odd ? wdata[15:8] : wdata[7:0])};
        rd_new[7:0]  = lanes[0] ? bus_in[7:0] : rd_old[7:0];
        rd_new[15:8] = lanes[1] ? (wide ? bus_in[15:8] : bus_in[7:0]) : rd_old[15:8];
    end
endmodule

// File: rtl/ebc_mux_bus.sv
module ebc_mux_bus
    import ebc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_adv,
    input  logic [1:0]        cfg_bw,
    input  logic              req,
    input  logic              req_we,
    input  logic              req_fetch,
    input  logic [LANES-1:0]  req_be,
    input  logic [BUS_W-1:0]  req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              ack,
    output logic [BUS_W-1:0]  rdata,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in,
    output logic              strobe,
    output logic              rd_n,
    output logic              wr_lo_n,
    output logic              wr_hi_n,
    output logic              inst,
    output logic              clkout,
    input  logic              ready,
    input  logic              buswidth
);
    seq_s             st_q, st_d;
    logic             we_eff;
    logic             wide_now;
    logic             in_cmd;
    logic [LANES-1:0] lanes;
    logic [BUS_W-1:0] bus_wr;
    logic [BUS_W-1:0] rd_new;

    ebc_lane_map u_lanes (
        .wide   (st_q.wide),
        .odd    (st_q.odd),
        .be     (req_be),
        .wdata  (req_wdata),
        .bus_in (ad_in),
        .rd_old (st_q.rdata),
        .lanes  (lanes),
        .bus_wr (bus_wr),
        .rd_new (rd_new)
    );

    ebc_strobe_enc u_enc (
        .ph       (st_q.ph),
        .adv_mode (cfg_adv),
        .we       (we_eff),
        .lanes    (lanes),
        .strobe   (strobe),
        .rd_n     (rd_n),
        .lo_n     (wr_lo_n),
        .hi_n     (wr_hi_n)
    );

    always_comb begin
        we_eff   = req_we && !req_fetch;
        wide_now = (&cfg_bw) ? buswidth : (cfg_bw == 2'b01);
        in_cmd   = (st_q.ph == PH_CMD) || (st_q.ph == PH_HOLD) ||
                   (st_q.ph == PH_WAITA) || (st_q.ph == PH_WAITB);
        st_d     = st_q;
        st_d.clk = ~st_q.clk;
        st_d.ack = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req && !st_q.ack && st_q.clk) begin
                    st_d.ph    = PH_ADDR;
                    st_d.odd   = (req_be == 2'b10);
                    st_d.more  = 1'b0;
                    st_d.rdata = '0;
                end
            end
            PH_ADDR: begin
                st_d.ph   = PH_CMD;
                st_d.wide = wide_now;
                st_d.more = !wide_now && (req_be == 2'b11) && !st_q.odd;
            end
            PH_CMD:   st_d.ph = PH_HOLD;
            PH_WAITA: st_d.ph = PH_WAITB;
            PH_HOLD, PH_WAITB: begin
                if (ready) begin
                    st_d.ph = PH_END;
                    if (!we_eff) st_d.rdata = rd_new;
                end else begin
                    st_d.ph = PH_WAITA;
                end
            end
            PH_END: begin
                if (st_q.more) begin
                    st_d.ph   = PH_ADDR;
                    st_d.odd  = 1'b1;
                    st_d.more = 1'b0;
                end else begin
                    st_d.ph  = PH_IDLE;
                    st_d.ack = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack    = st_q.ack;
    assign rdata  = st_q.rdata;
    assign clkout = st_q.clk;
    assign inst   = req_fetch && (st_q.ph != PH_IDLE);
    assign ad_oe  = (st_q.ph == PH_ADDR) || ((in_cmd || st_q.ph == PH_END) && we_eff);
    assign ad_out = (st_q.ph == PH_ADDR) ? {req_addr[BUS_W-1:1], st_q.odd} : bus_wr;

    p_ale_one_period_r1: assert property (@(posedge clk) disable iff (!rst_n || cfg_adv)
        $rose(strobe) |=> !strobe);
    p_addr_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_ADDR) |-> !clkout);
    p_ready_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_END) |-> $past(ready));
    p_adv_end_high_r5: assert property (@(posedge clk) disable iff (!rst_n || !cfg_adv)
        (st_q.ph == PH_END) |-> strobe);
    p_rw_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && (!wr_lo_n || !wr_hi_n)));
    p_clk_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (clkout != $past(clkout)));
    p_float_on_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: tb/ebc_mux_bus_bench.sv
module ebc_mux_bus_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_adv = 1'b0;
    logic [1:0]  cfg_bw = 2'b01;
    logic        req = 1'b0, req_we = 1'b0, req_fetch = 1'b0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        ack, ad_oe, strobe, rd_n, wr_lo_n, wr_hi_n, inst, clkout;
    logic [15:0] rdata, ad_out;
    logic [15:0] ad_in = '0;
    logic        ready = 1'b1, buswidth = 1'b0;

    int errors = 0, checks = 0;
    bit done = 0;
    bit mon_on = 0;
    bit e_wide = 0;
    int e_nwait = 0;
    int ncyc = 0, win_len = 0, ale_len = 0, since_start = 0, waited = 0;
    logic prev_strobe = 1'b0, prev_clk = 1'b0;
    logic [15:0] lat = '0;
    bit in_win = 0;

    ebc_mux_bus u_ebc_mux_bus (
        .clk(clk), .rst_n(rst_n), .cfg_adv(cfg_adv), .cfg_bw(cfg_bw),
        .req(req), .req_we(req_we), .req_fetch(req_fetch), .req_be(req_be),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .strobe(strobe),
        .rd_n(rd_n), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .inst(inst),
        .clkout(clkout), .ready(ready), .buswidth(buswidth)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] mb(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input int k);
        logic odd;
        odd = (k == 1) ? 1'b1 : (req_be == 2'b10);
        return {req_addr[15:1], odd};
    endfunction

    function automatic logic [1:0] exp_lanes(input int k);
        logic odd;
        odd = (k == 1) ? 1'b1 : (req_be == 2'b10);
        return e_wide ? req_be : (odd ? 2'b10 : 2'b01);
    endfunction

    // bus monitor and memory model
    always @(negedge clk) begin
        logic start, w;
        logic [1:0] ln;
        int k;
        if (mon_on) begin
            since_start++;
            chk(clkout != prev_clk, "R9", "clkout toggle", clkout, !prev_clk);
            start = cfg_adv ? (prev_strobe && !strobe) : (strobe && !prev_strobe);
            if (start) begin
                ncyc++;
                k = ncyc - 1;
                lat = ad_out;
                since_start = 0;
                waited = 0;
                chk(ad_oe == 1'b1, "R12", "oe in address period", ad_oe, 1);
                chk(ad_out == exp_addr(k), "R12", "address", ad_out, exp_addr(k));
                chk(clkout == 1'b0, "R1", "clkout in address period", clkout, 0);
                chk(inst == req_fetch, "R8", "inst at address", inst, req_fetch);
            end
            if (!cfg_adv) begin
                if (strobe) ale_len++;
                else if (ale_len > 0) begin
                    chk(ale_len == 1, "R1", "latch pulse width", ale_len, 1);
                    ale_len = 0;
                end
            end
            w = !rd_n || !wr_lo_n || !wr_hi_n;
            if (w && !in_win) begin
                ln = exp_lanes(ncyc - 1);
                chk(inst == req_fetch, "R8", "inst in command", inst, req_fetch);
                if (req_we) begin
                    chk(rd_n == 1'b1, "R6", "rd_n during write", rd_n, 1);
                    if (cfg_adv)
                        chk(wr_lo_n == !ln[0], "R7", "low-byte write strobe", wr_lo_n, !ln[0]);
                    else
                        chk(wr_lo_n == 1'b0, "R6", "write strobe", wr_lo_n, 0);
                    chk(wr_hi_n == !ln[1], cfg_adv ? "R7" : "R6", "high-byte strobe", wr_hi_n, !ln[1]);
                    if (e_wide) begin
                        if (ln[0]) chk(ad_out[7:0] == req_wdata[7:0], "R12", "low lane data", ad_out[7:0], req_wdata[7:0]);
                        if (ln[1]) chk(ad_out[15:8] == req_wdata[15:8], "R12", "high lane data", ad_out[15:8], req_wdata[15:8]);
                    end else begin
                        chk(ad_out[7:0] == (ln[1] ? req_wdata[15:8] : req_wdata[7:0]), "R12",
                            "byte data", ad_out[7:0], ln[1] ? req_wdata[15:8] : req_wdata[7:0]);
                    end
                end else begin
                    chk(rd_n == 1'b0, "R10", "rd_n on read", rd_n, 0);
                    chk(wr_lo_n && wr_hi_n, "R6", "write strobes on read", {wr_hi_n, wr_lo_n}, 3);
                end
            end
            if (w) begin
                win_len++;
                if (cfg_adv) chk(strobe == 1'b0, "R5", "valid level in command", strobe, 0);
                if (!rd_n) chk(ad_oe == 1'b0, "R10", "bus floats during read", ad_oe, 0);
                if (!clkout) begin
                    ready = (waited >= e_nwait);
                    if (!ready) waited++;
                end
            end
            if (!w && in_win) begin
                chk(win_len == 2 + 2 * e_nwait, "R2", "command length", win_len, 2 + 2 * e_nwait);
                if (cfg_adv) chk(strobe == 1'b1, "R5", "valid high at end", strobe, 1);
                win_len = 0;
            end
            in_win = w;
            ad_in = {mb({lat[15:1], 1'b1}), e_wide ? mb({lat[15:1], 1'b0}) : mb(lat)};
        end
        prev_strobe = strobe;
        prev_clk = clkout;
    end

    task automatic do_req(input bit we, input bit fetch, input logic [1:0] be,
                          input logic [15:0] addr, input logic [15:0] wd, input int nw);
        int t;
        int ncyc_exp;
        logic [15:0] rexp;
        @(negedge clk); #1;
        req_we = we; req_fetch = fetch; req_be = be; req_addr = addr; req_wdata = wd;
        e_nwait = nw; ncyc = 0;
        req = 1'b1;
        t = 0;
        do begin
            @(negedge clk); #1;
            t++;
        end while (!ack && t < 200);
        chk(ack == 1'b1, "R11", "ack arrives", ack, 1);
        ncyc_exp = (!e_wide && be == 2'b11) ? 2 : 1;
        chk(ncyc == ncyc_exp, "R4", "cycle count", ncyc, ncyc_exp);
        chk(since_start == 4 + 2 * nw, "R1", "last cycle length to ack", since_start, 4 + 2 * nw);
        if (!we || fetch) begin
            rexp = {be[1] ? mb({addr[15:1], 1'b1}) : 8'h00, be[0] ? mb({addr[15:1], 1'b0}) : 8'h00};
            chk(rdata == rexp, "R10", "read data", rdata, rexp);
        end
        req = 1'b0;
        @(negedge clk); #1;
        chk(ack == 1'b0, "R11", "ack one cycle", ack, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(ack == 1'b0, "R11", "reset ack", ack, 0);
        chk({rd_n, wr_lo_n, wr_hi_n} == 3'b111, "R11", "reset strobes", {rd_n, wr_lo_n, wr_hi_n}, 7);
        chk(ad_oe == 1'b0, "R11", "reset oe", ad_oe, 0);
        chk(inst == 1'b0, "R11", "reset inst", inst, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        mon_on = 1;
        for (int m = 0; m < 2; m++) begin
            cfg_adv = m[0];
            @(negedge clk); #1;
            chk(strobe == m[0], m[0] ? "R5" : "R1", "idle strobe", strobe, m[0]);
            for (int wc = 0; wc < 5; wc++) begin
                case (wc)
                    0: begin cfg_bw = 2'b01; e_wide = 1; buswidth = 1'b0; end
                    1: begin cfg_bw = 2'b00; e_wide = 0; buswidth = 1'b1; end
                    2: begin cfg_bw = 2'b10; e_wide = 0; buswidth = 1'b1; end
                    3: begin cfg_bw = 2'b11; e_wide = 0; buswidth = 1'b0; end
                    default: begin cfg_bw = 2'b11; e_wide = 1; buswidth = 1'b1; end
                endcase
                // R3: fixed widths run with the width pin at the opposite value
                for (int b = 1; b < 4; b++) begin
                    for (int op = 0; op < 3; op++) begin
                        for (int nw = 0; nw < 4; nw += (nw == 0 ? 1 : 2)) begin
                            idx++;
                            do_req(op == 1, op == 2, b[1:0], 16'h1230 + 16'(idx * 4),
                                   {8'(idx) ^ 8'h3C, 8'(idx) + 8'h11}, nw);
                        end
                    end
                end
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule